// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a memory-mapped interval timer with a parameterised number of counting channels. A global run register holds one enable bit per channel. Each channel owns a control/status word, an up-counter and a compare word. All of them are reached through a single-cycle synchronous register bus that uses word indices. Each channel has its own divider. The divider turns the peripheral clock into count-enable pulses, so the counter runs as a clock-enable domain of the peripheral clock.

When a counting pulse finds the counter equal to the compare word, the counter returns to zero and the match flag sets. The period is therefore compare+1 counts. A counter that passes all ones without a match wraps to zero and sets an overflow flag. Software clears a flag by writing the control word back with that bit at zero. A level interrupt per channel follows the match flag while the interrupt is enabled and routed. A counter write is held back and reaches the running count only on the second counting pulse after the write. A status bit shows the pending write.

A narrow-layout variant can be selected by parameter. It has a 2-bit clock select (divide by 8, 32, 128, 512), the match flag in bit 7, the interrupt enable in bit 6, and no overflow flag.

Top module: `cmp_interval_timer`

## Requirements
- R1: After reset, every register reads zero and every interrupt output is low.
- R2: Word 0 is the run register, with bit c for channel c. Channel c occupies words 4(c+1)+0, +1 and +2: control, counter and compare. Word +3 reads zero. In the wide layout, the control bits 12..7 and 5..0 read back as written. The compare word reads back truncated to the counter width.
- R3: Clock-select field bits 2:0 codes 4, 5, 6 and 7 give one count every 8, 32, 128 and 1 clocks while the channel runs. After the run bit is set, the counter reads floor(k/N) k clocks later. Codes 0 to 3 never count.
- R4: On a count with counter equal to compare, the counter becomes zero and control bit 15 (match flag) sets. The counter therefore cycles through compare+1 values.
- R5: On a count with counter at all ones and no match, the counter wraps to zero and control bit 14 (overflow flag) sets. Bit 15 is left unchanged.
- R6: Writing a control word with bit 15 or bit 14 at zero clears that flag. Writing it at one leaves the flag as it was.
- R7: The interrupt of a channel is a level equal to bit 15 AND bit 7 (enable) AND (bits 5:4 == 2). It stays high until the flag is cleared, even while the channel is stopped.
- R8: A channel with its run bit at zero holds its counter. Changing one channel's run bit does not disturb another channel.
- R9: A counter write loads the counter on the second count after the write. Until then reads return the value still counting from the old one, and control bit 13 reads one while the write is pending.
- R10: A compare write takes part in the very next comparison.
- R11: With compare at all ones and the counter at zero, the first match comes after 2^CW counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high with bus_sel |
| bus_addr | input | AW | Word index |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| irq | output | NCH | Level interrupt per channel |

## Verification
Reads are combinational, so the bench samples them just after a falling edge without advancing time. A write lands on the next rising edge. With divide-by-1, the counter seen k falling edges after the run write is k modulo the period. With divide-by-N it is floor(k/N), because the divider starts from zero at that edge. A counter write taken on edge W shows the new value only after edge W+2, and the bench reads at W, W+1 and W+2 to confirm the old value, the pending bit and the load. The match flag and the interrupt are checked on the falling edge right after the counting pulse that found the match. A compare write counts as effective from the edge on which it lands.

// File: rtl/cit_pkg.sv
package cit_pkg;
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_CNT  = 2'd1,
      REG_CMP  = 2'd2,
      REG_NONE = 2'd3
   } cit_reg_e;

   typedef struct packed {
      logic       ok;
      logic [3:0] log2;
   } cit_div_t;

   localparam int WIDE_MF   = 15;
   localparam int WIDE_OF   = 14;
   localparam int WIDE_PEND = 13;
   localparam int NARROW_MF = 7;
   localparam int NARROW_IE = 6;

   function automatic cit_div_t div_decode(input bit narrow, input logic [2:0] code);
      cit_div_t d;
      d.ok   = 1'b1;
      d.log2 = 4'd0;
      if (narrow) begin
         case (code[1:0])
            2'd0:    d.log2 = 4'd3;
            2'd1:    d.log2 = 4'd5;
            2'd2:    d.log2 = 4'd7;
            default: d.log2 = 4'd9;
         endcase
      end else begin
         case (code)
            3'd4:    d.log2 = 4'd3;
            3'd5:    d.log2 = 4'd5;
            3'd6:    d.log2 = 4'd7;
            3'd7:    d.log2 = 4'd0;
            default: d.ok   = 1'b0;
         endcase
      end
      return d;
   endfunction
endpackage

// File: rtl/cit_prescaler.sv
module cit_prescaler
   import cit_pkg::*;
#(
   parameter int PRE_W = 9
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   input  cit_div_t div,
   output logic     tick
);
   logic [PRE_W-1:0] pcnt_q;
   logic [PRE_W-1:0] mask;

   if (PRE_W < 9) begin : g_bad_pre_w
      $error("cit_prescaler: PRE_W must cover divide by 512");
   end

   assign mask = ~({PRE_W{1'b1}} << div.log2);
   assign tick = run & div.ok & ((pcnt_q & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) pcnt_q <= '0;
      else                pcnt_q <= pcnt_q + 1'b1;
   end
endmodule

// File: rtl/cit_channel.sv
module cit_channel
   import cit_pkg::*;
#(
   parameter int CW     = 32,
   parameter int DW     = 32,
   parameter int NARROW = 0,
   parameter int PRE_W  = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          wr_ctrl,
   input  logic          wr_cnt,
   input  logic          wr_cmp,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] ctrl_rd,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] cmp_q,
   output logic          mflag_q,
   output logic          irq
);
   localparam int MF      = (NARROW != 0) ? NARROW_MF : WIDE_MF;
   localparam bit HAS_OVF = (NARROW == 0);

   logic [DW-1:0] ctrl_q, wmask;
   logic          oflag_q, pend_q, pstage_q;
   logic [CW-1:0] pval_q;
   logic [CW-1:0] cnt_n, pval_n;
   logic          pend_n, pstage_n, mset, oset, mflag_n, oflag_n;
   logic [2:0]    sel;
   logic          ie_eff, tick;
   cit_div_t      dv;

   if (NARROW != 0) begin : g_narrow
      assign wmask  = DW'(32'h0000_0043);
      assign sel    = {1'b0, ctrl_q[1:0]};
      assign ie_eff = ctrl_q[NARROW_IE];
      always_comb begin
         ctrl_rd            = ctrl_q;
         ctrl_rd[NARROW_MF] = mflag_q;
      end
   end else begin : g_wide
      assign wmask  = DW'(32'h0000_1FBF);
      assign sel    = ctrl_q[2:0];
      assign ie_eff = ctrl_q[7] & (ctrl_q[5:4] == 2'b10);
      always_comb begin
         ctrl_rd            = ctrl_q;
         ctrl_rd[WIDE_MF]   = mflag_q;
         ctrl_rd[WIDE_OF]   = oflag_q;
         ctrl_rd[WIDE_PEND] = pend_q;
      end
   end

   assign dv = div_decode(NARROW != 0, sel);

   cit_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .div  (dv),
      .tick (tick)
   );

   always_comb begin
      cnt_n    = cnt_q;
      pend_n   = pend_q;
      pstage_n = pstage_q;
      pval_n   = pval_q;
      mset     = 1'b0;
      oset     = 1'b0;
      if (tick) begin
         if (pend_q && pstage_q) begin
            cnt_n    = pval_q;
            pend_n   = 1'b0;
            pstage_n = 1'b0;
         end else begin
            if (pend_q) pstage_n = 1'b1;
            if (cnt_q == cmp_q) begin
               cnt_n = '0;
               mset  = 1'b1;
            end else if (&cnt_q) begin
               cnt_n = '0;
               oset  = HAS_OVF;
            end else begin
               cnt_n = cnt_q + 1'b1;
            end
         end
      end
      if (wr_cnt) begin
         pend_n   = 1'b1;
         pstage_n = 1'b0;
         pval_n   = wdata[CW-1:0];
      end
      mflag_n = (wr_ctrl ? (mflag_q & wdata[MF])      : mflag_q) | mset;
      oflag_n = (wr_ctrl ? (oflag_q & wdata[WIDE_OF]) : oflag_q) | oset;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         cnt_q    <= '0;
         cmp_q    <= '0;
         pval_q   <= '0;
         pend_q   <= 1'b0;
         pstage_q <= 1'b0;
         mflag_q  <= 1'b0;
         oflag_q  <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata & wmask;
         if (wr_cmp)  cmp_q  <= wdata[CW-1:0];
         cnt_q    <= cnt_n;
         pval_q   <= pval_n;
         pend_q   <= pend_n;
         pstage_q <= pstage_n;
         mflag_q  <= mflag_n;
         oflag_q  <= oflag_n;
      end
   end

   assign irq = mflag_q & ie_eff;
endmodule

// File: rtl/cmp_interval_timer.sv
module cmp_interval_timer
   import cit_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int CW     = 32,
   parameter int DW     = 32,
   parameter int AW     = 6,
   parameter int NARROW = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_sel,
   input  logic           bus_we,
   input  logic [AW-1:0]  bus_addr,
   input  logic [DW-1:0]  bus_wdata,
   output logic [DW-1:0]  bus_rdata,
   output logic [NCH-1:0] irq
);
   localparam int PRE_W = 9;
   localparam int BW    = AW - 2;

   if (CW > DW)               begin : g_bad_cw   $error("CW wider than DW");        end
   if (DW < 16)               begin : g_bad_dw   $error("DW must be at least 16");  end
   if (NCH > DW)              begin : g_bad_nch  $error("NCH exceeds run width");    end
   if ((NCH + 1) * 4 > 2**AW) begin : g_bad_aw   $error("AW too small for NCH");    end

   logic [BW-1:0]     blk;
   cit_reg_e          rsel;
   logic              wr_any;
   logic [NCH-1:0]    start_q;
   logic [DW-1:0]     ctrl_a [NCH];
   logic [CW-1:0]     cnt_a  [NCH];
   logic [CW-1:0]     cmp_a  [NCH];
   logic [NCH*CW-1:0] cnt_vec, cmp_vec;
   logic [NCH-1:0]    mflag_vec;

   assign blk    = bus_addr[AW-1:2];
   assign rsel   = cit_reg_e'(bus_addr[1:0]);
   assign wr_any = bus_sel & bus_we;

   always_ff @(posedge clk) begin
      if (!rst_n)                             start_q <= '0;
      else if (wr_any && (bus_addr == '0))    start_q <= bus_wdata[NCH-1:0];
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit;
      assign hit = wr_any && (blk == BW'(c + 1));

      cit_channel #(.CW(CW), .DW(DW), .NARROW(NARROW), .PRE_W(PRE_W)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (start_q[c]),
         .wr_ctrl(hit && (rsel == REG_CTRL)),
         .wr_cnt (hit && (rsel == REG_CNT)),
         .wr_cmp (hit && (rsel == REG_CMP)),
         .wdata  (bus_wdata),
         .ctrl_rd(ctrl_a[c]),
         .cnt_q  (cnt_a[c]),
         .cmp_q  (cmp_a[c]),
         .mflag_q(mflag_vec[c]),
         .irq    (irq[c])
      );

      assign cnt_vec[c*CW +: CW] = cnt_a[c];
      assign cmp_vec[c*CW +: CW] = cmp_a[c];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == '0) bus_rdata = DW'(start_q);
      for (int c = 0; c < NCH; c++) begin
         if (blk == BW'(c + 1)) begin
            case (rsel)
               REG_CTRL: bus_rdata = ctrl_a[c];
               REG_CNT:  bus_rdata = DW'(cnt_a[c]);
               REG_CMP:  bus_rdata = DW'(cmp_a[c]);
               default:  bus_rdata = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/cit_checker.sv
module cit_checker #(
   parameter int NCH = 2,
   parameter int CW  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [NCH-1:0]    start_q,
   input logic [NCH*CW-1:0] cnt_vec,
   input logic [NCH*CW-1:0] cmp_vec,
   input logic [NCH-1:0]    mflag_vec,
   input logic [NCH-1:0]    irq
);
   for (genvar c = 0; c < NCH; c++) begin : g_chk
      // R8: a stopped channel keeps its count
      a_r8_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !start_q[c] |=> $stable(cnt_vec[c*CW +: CW]));

      // R4: the match flag only rises on a match that clears the counter
      a_r4_match_clear: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(mflag_vec[c]) |-> (($past(cnt_vec[c*CW +: CW]) == $past(cmp_vec[c*CW +: CW]))
                                  && (cnt_vec[c*CW +: CW] == '0)));

      // R7: interrupt never without the match flag
      a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
         irq[c] |-> mflag_vec[c]);

      // R6: the flag only drops after a bus write
      a_r6_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(mflag_vec[c]) |-> $past(bus_sel && bus_we));
   end
endmodule

bind cmp_interval_timer cit_checker #(.NCH(NCH), .CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_we   (bus_we),
   .start_q  (start_q),
   .cnt_vec  (cnt_vec),
   .cmp_vec  (cmp_vec),
   .mflag_vec(mflag_vec),
   .irq      (irq)
);

// File: tb/cmp_interval_timer_tb_top.sv
`timescale 1ns/1ps
module cmp_interval_timer_tb_top;
   localparam int NCH = 2;
   localparam int CW  = 8;
   localparam int DW  = 32;
   localparam int AW  = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bus_sel = 1'b0;
   logic           bus_we = 1'b0;
   logic [AW-1:0]  bus_addr = '0;
   logic [DW-1:0]  bus_wdata = '0;
   logic [DW-1:0]  bus_rdata;
   logic [NCH-1:0] irq;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   cmp_interval_timer #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW), .NARROW(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   localparam logic [AW-1:0] A_RUN = 6'd0;
   function automatic logic [AW-1:0] a_ctl(input int c); return AW'(4*(c+1));     endfunction
   function automatic logic [AW-1:0] a_cnt(input int c); return AW'(4*(c+1) + 1); endfunction
   function automatic logic [AW-1:0] a_cmp(input int c); return AW'(4*(c+1) + 2); endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      bus_sel = 1'b0; bus_we = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      logic [DW-1:0] v;
      int divs[4];
      divs[0] = 8; divs[1] = 32; divs[2] = 128; divs[3] = 1;

      // R1: reset state
      do_reset();
      for (int a = 0; a < 12; a++) begin
         rd(AW'(a), v);
         check("R1 reset register", v, 32'h0);
      end
      check("R1 reset irq", 32'(irq), 32'h0);

      // R2: register map and readback
      wr(a_ctl(0), 32'h0000_FFFF);
      rd(a_ctl(0), v); check("R2 ctrl writable bits", v, 32'h0000_1FBF);
      wr(a_cmp(1), 32'h0000_01A5);
      rd(a_cmp(1), v); check("R2 compare truncation", v, 32'h0000_00A5);
      rd(a_cmp(0), v); check("R2 other channel compare", v, 32'h0);
      rd(AW'(7), v);   check("R2 unused word", v, 32'h0);
      wr(A_RUN, 32'h0000_00FF);
      rd(A_RUN, v);    check("R2 run register", v, 32'h3);

      // R3: prescaler codes 4..7
      for (int i = 0; i < 4; i++) begin
         do_reset();
         wr(a_cmp(0), 32'hFF);
         wr(a_ctl(0), 32'(4 + i));
         wr(A_RUN, 32'h1);
         for (int k = 1; k <= 300; k++) begin
            wait_n(1);
            rd(a_cnt(0), v);
            check("R3 divided count", v, 32'((k / divs[i]) % 256));
         end
      end
      // R3: codes 0..3 do not count
      for (int code = 0; code < 4; code++) begin
         do_reset();
         wr(a_cmp(0), 32'hFF);
         wr(a_ctl(0), 32'(code));
         wr(A_RUN, 32'h1);
         wait_n(200);
         rd(a_cnt(0), v);
         check("R3 idle code", v, 32'h0);
      end

      // R4: period compare+1 for small compare values
      for (int m = 0; m < 6; m++) begin
         do_reset();
         wr(a_cmp(0), 32'(m));
         wr(a_ctl(0), 32'h7);
         wr(A_RUN, 32'h1);
         for (int k = 1; k <= 20; k++) begin
            wait_n(1);
            rd(a_cnt(0), v);
            check("R4 count modulo period", v, 32'(k % (m + 1)));
            rd(a_ctl(0), v);
            check("R4 match flag", 32'(v[15]), 32'(k > m));
         end
      end

      // R11: full range before first match
      do_reset();
      wr(a_cmp(0), 32'hFF);
      wr(a_ctl(0), 32'h7);
      wr(A_RUN, 32'h1);
      wait_n(255);
      rd(a_cnt(0), v); check("R11 top of range", v, 32'hFF);
      rd(a_ctl(0), v); check("R11 no early flag", 32'(v[15]), 32'h0);
      wait_n(1);
      rd(a_cnt(0), v); check("R11 wrap on match", v, 32'h0);
      rd(a_ctl(0), v); check("R11 flag after full range", 32'(v[15]), 32'h1);

      // R5: overflow past all ones, R9 delayed load, R6 overflow clear
      do_reset();
      wr(a_ctl(0), 32'h7);
      wr(a_cmp(0), 32'd10);
      wr(A_RUN, 32'h1);
      wr(a_cnt(0), 32'd200);
      wait_n(2);
      rd(a_cnt(0), v); check("R9 loaded value", v, 32'd200);
      wait_n(55);
      rd(a_cnt(0), v); check("R5 at all ones", v, 32'hFF);
      rd(a_ctl(0), v); check("R5 no overflow yet", 32'(v[14]), 32'h0);
      wait_n(1);
      rd(a_cnt(0), v); check("R5 wrap to zero", v, 32'h0);
      rd(a_ctl(0), v); check("R5 overflow flag", 32'(v[14]), 32'h1);
      check("R5 match flag untouched", 32'(v[15]), 32'h0);
      wr(a_ctl(0), 32'h4007);
      rd(a_ctl(0), v); check("R6 overflow write one keeps", 32'(v[14]), 32'h1);
      wr(a_ctl(0), 32'h0007);
      rd(a_ctl(0), v); check("R6 overflow write zero clears", v, 32'h0007);

      // R9: pending window
      do_reset();
      wr(a_ctl(0), 32'h7);
      wr(a_cmp(0), 32'hFF);
      wr(A_RUN, 32'h1);
      wait_n(10);
      rd(a_cnt(0), v); check("R9 before write", v, 32'd10);
      wr(a_cnt(0), 32'd50);
      rd(a_cnt(0), v); check("R9 old value first", v, 32'd11);
      rd(a_ctl(0), v); check("R9 pending bit", v, 32'h2007);
      wait_n(1);
      rd(a_cnt(0), v); check("R9 old value second", v, 32'd12);
      rd(a_ctl(0), v); check("R9 still pending", 32'(v[13]), 32'h1);
      wait_n(1);
      rd(a_cnt(0), v); check("R9 new value", v, 32'd50);
      rd(a_ctl(0), v); check("R9 pending cleared", v, 32'h0007);
      wait_n(1);
      rd(a_cnt(0), v); check("R9 counts on", v, 32'd51);

      // R8: independent start/stop
      do_reset();
      for (int c = 0; c < 2; c++) begin
         wr(a_ctl(c), 32'h7);
         wr(a_cmp(c), 32'hFF);
      end
      wr(A_RUN, 32'h3);
      wait_n(20);
      wr(A_RUN, 32'h1);
      rd(a_cnt(1), v); check("R8 stop edge ch1", v, 32'd21);
      wait_n(30);
      rd(a_cnt(0), v); check("R8 ch0 keeps running", v, 32'd51);
      rd(a_cnt(1), v); check("R8 ch1 held", v, 32'd21);
      wr(A_RUN, 32'h3);
      rd(a_cnt(0), v); check("R8 ch0 at restart", v, 32'd52);
      rd(a_cnt(1), v); check("R8 ch1 at restart", v, 32'd21);
      wait_n(5);
      rd(a_cnt(0), v); check("R8 ch0 after", v, 32'd57);
      rd(a_cnt(1), v); check("R8 ch1 resumed", v, 32'd26);

      // R10: compare write joins the next comparison
      do_reset();
      wr(a_ctl(0), 32'h7);
      wr(a_cmp(0), 32'hFF);
      wr(A_RUN, 32'h1);
      wait_n(5);
      wr(a_cmp(0), 32'd8);
      rd(a_cnt(0), v); check("R10 count at write", v, 32'd6);
      wait_n(2);
      rd(a_cnt(0), v); check("R10 reach new compare", v, 32'd8);
      rd(a_ctl(0), v); check("R10 no flag yet", 32'(v[15]), 32'h0);
      wait_n(1);
      rd(a_cnt(0), v); check("R10 cleared on new compare", v, 32'h0);
      rd(a_ctl(0), v); check("R10 flag on new compare", 32'(v[15]), 32'h1);

      // R7 and R6: level interrupt and flag clearing
      do_reset();
      wr(a_ctl(0), 32'hA7);
      wr(a_ctl(1), 32'h87);
      wr(a_cmp(0), 32'd3);
      wr(a_cmp(1), 32'd3);
      wr(A_RUN, 32'h3);
      wait_n(3);
      check("R7 irq low before match", 32'(irq), 32'h0);
      wait_n(1);
      check("R7 irq only when routed", 32'(irq), 32'h1);
      rd(a_ctl(1), v); check("R7 unrouted flag set", 32'(v[15]), 32'h1);
      wr(A_RUN, 32'h0);
      check("R7 irq held while stopped", 32'(irq), 32'h1);
      wr(a_ctl(0), 32'h80A7);
      rd(a_ctl(0), v); check("R6 write one keeps flag", 32'(v[15]), 32'h1);
      check("R6 irq kept", 32'(irq), 32'h1);
      wr(a_ctl(0), 32'h00A7);
      rd(a_ctl(0), v); check("R6 write zero clears", v, 32'h00A7);
      check("R6 irq drops", 32'(irq), 32'h0);
      wait_n(10);
      check("R7 irq stays low", 32'(irq), 32'h0);

      summary();
   end
endmodule